// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write a byte-wide asynchronous static RAM. The RAM has 17 address bits, an active-low select, an active-high select, an active-low write strobe and an active-low output enable. Data moves over one shared bidirectional bus. On the system side a request carries an address, a write flag and write data. The controller turns it into a pin sequence whose length in clock cycles is derived from nanosecond timing parameters. A single-cycle ready pulse marks completion. After a read, the captured byte stays on a registered result port.

Every timing count is the ceiling of a nanosecond figure divided by the clock period, with a minimum of one cycle. With no request pending, the memory is held deselected so that it stays in standby. A write is closed by raising the write strobe while both selects remain active. The output enable stays high throughout a write, so the memory never drives the bus against the controller. After every read the controller waits out the memory's output-release time before it may drive the bus again.

Top module: `sram_ctrl_top`

## Requirements
- R1: After reset, and whenever no access is in progress, the pins are mem_sel_n=1, mem_sel=0, mem_we_n=1 and mem_oe_n=1, and req_ready=0.
- R2: During a read the memory is selected (mem_sel_n=0, mem_sel=1) with mem_we_n=1, mem_oe_n=0, and mem_addr equal to the requested address.
- R3: A read samples the bus and pulses req_ready for exactly one cycle. This happens max(ceil(55/T), ceil(20/T), ceil(55/T)) cycles after the select pins assert, which is 11 cycles at T=5 ns. rd_data then equals the byte last written to that address, or 0 if the address was never written.
- R4: rd_data changes only on the cycle a read completes and holds its value across writes and idle time.
- R5: A write holds mem_we_n low for max(ceil(45/T), ceil(45/T), ceil(25/T)) cycles, which is 9 at T=5 ns. Address, selects and write data are applied on the same edge that lowers mem_we_n.
- R6: The write ends by raising mem_we_n while both selects stay asserted and data stays driven for max(1, ceil(55/T) − pulse) cycles, which is 2 at T=5 ns. req_ready pulses 11 cycles after the selects assert.
- R7: mem_addr never changes while the memory stays selected across a clock edge. Successive address changes are at least 55 ns apart, with a deselected cycle in between.
- R8: mem_oe_n is high whenever the controller drives the bus or mem_we_n is low. After a read, at least ceil(20/T) cycles pass between mem_oe_n rising and the next mem_we_n falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_sel | output | 1 | Active-high memory select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq | inout | 8 | Shared data bus |

## Verification
At a 5 ns clock, both a read result and a write completion are due 11 cycles after the select pins assert. The write strobe is due to stay low for 9 of those cycles, and the closing phase to last 2. The bench stamps the time of the select edge and of the ready pulse, and compares their difference with latencies its own functions compute from the nanosecond figures. It samples and counts pin states on falling clock edges only. A behavioural memory model in the bench returns inverted data until both the 55 ns and 20 ns access windows have elapsed, so a capture that comes too early reads the wrong byte. The model also measures pulse width, setup times and the turnaround gap at each strobe edge.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WEND   = 3'd3,
    ST_TURN   = 3'd4
  } seq_state_t;

  // ceiling of ns / period, never below one cycle
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(max2(a, b), c);
  endfunction

  function automatic int width_for(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int N_READ   = 11,
  parameter int N_WPULSE = 9,
  parameter int N_WEND   = 2,
  parameter int N_TURN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output seq_state_t state_q,
  output seq_state_t nxt_state,
  output logic       accept,
  output logic       capture,
  output logic       done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign capture  = (state_q == ST_READ) && cnt_zero;
  assign done     = capture || ((state_q == ST_WEND) && cnt_zero);

  always_comb begin
    nxt_state = state_q;
    cnt_d     = cnt_zero ? '0 : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            nxt_state = ST_WPULSE;
            cnt_d     = CNT_W'(N_WPULSE - 1);
          end else begin
            nxt_state = ST_READ;
            cnt_d     = CNT_W'(N_READ - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          nxt_state = ST_TURN;
          cnt_d     = CNT_W'(N_TURN - 1);
        end
      end
      ST_WPULSE: begin
        if (cnt_zero) begin
          nxt_state = ST_WEND;
          cnt_d     = CNT_W'(N_WEND - 1);
        end
      end
      ST_WEND: if (cnt_zero) nxt_state = ST_IDLE;
      ST_TURN: if (cnt_zero) nxt_state = ST_IDLE;
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= cnt_d;
    end
  end

  // a read always goes through the turnaround state before idle
  assert_read_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state_q == ST_TURN));

endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
module sram_pin_drive
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 4,
  parameter int N_WPULSE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        nxt_state,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_n_q,
  output logic              sel_q,
  output logic              we_n_q,
  output logic              oe_n_q,
  output logic              drive_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic active_d;
  logic write_d;
  logic [CNT_W-1:0] we_low_cnt;

  assign active_d = (nxt_state == ST_READ) || (nxt_state == ST_WPULSE) ||
                    (nxt_state == ST_WEND);
  assign write_d  = (nxt_state == ST_WPULSE) || (nxt_state == ST_WEND);

  // pins come straight from flops so the strobes cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_q <= 1'b1;
      sel_q   <= 1'b0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drive_q <= 1'b0;
    end else begin
      sel_n_q <= !active_d;
      sel_q   <= active_d;
      we_n_q  <= !(nxt_state == ST_WPULSE);
      oe_n_q  <= !(nxt_state == ST_READ);
      drive_q <= write_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       we_low_cnt <= '0;
    else if (!we_n_q) we_low_cnt <= we_low_cnt + 1'b1;
    else              we_low_cnt <= '0;
  end

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (we_low_cnt == CNT_W'(N_WPULSE)));

  assert_we_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (!sel_n_q && sel_q));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && $past(sel_q)) |-> $stable(addr_q));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q || !we_n_q) |-> oe_n_q);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= dq_in;
  end

  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rd_data));

endmodule

// File: rtl/sram_ctrl_top.sv
`timescale 1ns/1ps
module sram_ctrl_top
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_ADDR_ACC_NS = 55,
  parameter int T_OE_ACC_NS   = 20,
  parameter int T_WE_PULSE_NS = 45,
  parameter int T_ADDR_WE_NS  = 45,
  parameter int T_DATA_WE_NS  = 25,
  parameter int T_OUT_OFF_NS  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int N_CYCLE  = ns_to_cycles(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int N_READ   = max3(ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS), N_CYCLE);
  localparam int N_WPULSE = max3(ns_to_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_ADDR_WE_NS, CLK_PERIOD_NS),
                                 ns_to_cycles(T_DATA_WE_NS, CLK_PERIOD_NS));
  localparam int N_WEND   = max2(1, N_CYCLE - N_WPULSE);
  localparam int N_TURN   = ns_to_cycles(T_OUT_OFF_NS, CLK_PERIOD_NS);
  localparam int N_MAX    = max3(N_READ, N_WPULSE, max2(N_WEND, N_TURN));
  localparam int CNT_W    = width_for(N_MAX);

  seq_state_t        state_q;
  seq_state_t        nxt_state;
  logic              accept;
  logic              capture;
  logic              done;
  logic              drive;
  logic [DATA_W-1:0] wdata;

  sram_seq_fsm #(
    .CNT_W(CNT_W), .N_READ(N_READ), .N_WPULSE(N_WPULSE),
    .N_WEND(N_WEND), .N_TURN(N_TURN)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .state_q(state_q), .nxt_state(nxt_state), .accept(accept),
    .capture(capture), .done(done)
  );

  sram_pin_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .N_WPULSE(N_WPULSE)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .nxt_state(nxt_state), .accept(accept),
    .req_addr(req_addr), .req_wdata(req_wdata), .addr_q(mem_addr),
    .sel_n_q(mem_sel_n), .sel_q(mem_sel), .we_n_q(mem_we_n),
    .oe_n_q(mem_oe_n), .drive_q(drive), .wdata_q(wdata)
  );

  sram_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(mem_dq),
    .rd_data(rd_data)
  );

  assign mem_dq = drive ? wdata : {DATA_W{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_ready <= 1'b0;
    else        req_ready <= done;
  end

  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE || state_q == ST_TURN) |->
      (mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !drive));

endmodule

// File: tb/sram_ctrl_top_tb.sv
`timescale 1ns/1ps
module sram_ctrl_top_tb;

  localparam real PER = 5.0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n;
  wire  [7:0]  dq;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sram_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq(dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected cycle counts restated from the requirements
  function automatic int cyc(input int ns);
    int c;
    c = ns / 5;
    if (c * 5 < ns) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction
  function automatic int bigger(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction
  int exp_rd_lat, exp_wp, exp_tail, exp_turn;

  // behavioural memory model with timing checks
  logic [7:0] sram_mem [int];
  logic [7:0] exp_mem  [int];
  logic [7:0] m_out = 8'h00;
  logic       m_drv = 1'b0;
  real t_addr = 0.0, t_oe_fall = 0.0, t_oe_rise = -1000.0;
  real t_we_fall = 0.0, t_dq = 0.0, t_sel = 0.0;
  bit  had_read = 1'b0;

  assign dq = m_drv ? m_out : 8'bz;

  always @(mem_addr)         t_addr = $realtime;
  always @(negedge mem_oe_n) t_oe_fall = $realtime;
  always @(posedge mem_oe_n) begin t_oe_rise = $realtime; had_read = 1'b1; end
  always @(dq)               t_dq = $realtime;
  always @(negedge mem_sel_n) t_sel = $realtime;

  always #1 begin : model_out
    logic [7:0] stored;
    bit act;
    act = !mem_sel_n && mem_sel && mem_we_n && !mem_oe_n;
    m_drv = act;
    if (act) begin
      stored = sram_mem.exists(int'(mem_addr)) ? sram_mem[int'(mem_addr)] : 8'h00;
      if (($realtime - t_addr >= 54.0) && ($realtime - t_oe_fall >= 19.0))
        m_out = stored;
      else
        m_out = ~stored;
    end
  end

  always @(negedge mem_we_n) begin
    t_we_fall = $realtime;
    if (had_read)
      chk($realtime - t_oe_rise >= 20.0, "R8 oe-rise to we-fall ns",
          int'($realtime - t_oe_rise), 20);
  end

  always @(posedge mem_we_n) begin
    if (rst_n) begin
      chk($realtime - t_we_fall >= 45.0, "R5 we pulse ns", int'($realtime - t_we_fall), 45);
      chk($realtime - t_addr >= 45.0, "R5 addr setup ns", int'($realtime - t_addr), 45);
      chk($realtime - t_dq >= 25.0, "R5 data setup ns", int'($realtime - t_dq), 25);
      chk(!mem_sel_n && mem_sel, "R6 selects held at we rise", {mem_sel_n, mem_sel}, 1);
      sram_mem[int'(mem_addr)] = dq;
    end
  end

  // address stability and cycle time sampled on falling edges
  logic [16:0] prev_addr = '0;
  bit          prev_sel  = 1'b0;
  real         t_chg     = -1000.0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_addr != prev_addr) begin
        chk(!prev_sel, "R7 address moved while selected", int'(mem_addr), int'(prev_addr));
        chk($realtime - t_chg >= 55.0, "R7 address cycle ns", int'($realtime - t_chg), 55);
        t_chg = $realtime;
      end
      chk(!(!mem_oe_n && !mem_we_n), "R8 oe and we both low", mem_oe_n, 1);
    end
    prev_addr = mem_addr;
    prev_sel  = !mem_sel_n;
  end

  logic [7:0] last_rd = 8'h00;

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int we_low, tail, n, lat, expv;
    bit fin;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    we_low = 0; tail = 0; n = 0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      n++;
      if (req_ready) fin = 1'b1;
      else if (!mem_sel_n) begin
        if (wr) begin
          if (!mem_we_n) we_low++; else tail++;
          chk(mem_oe_n && mem_sel && mem_addr == a, "R5 write pin state", mem_oe_n, 1);
        end else begin
          chk(mem_we_n && !mem_oe_n && mem_sel && mem_addr == a,
              "R2 read pin state", {mem_we_n, mem_oe_n, mem_sel}, 3'b101);
        end
      end
      if (n > 300) begin
        chk(1'b0, "watchdog R3 no ready", n, 300);
        fin = 1'b1;
      end
    end
    req_valid = 1'b0;
    lat = int'(($realtime - 2.5 - t_sel) / PER);
    if (wr) begin
      chk(lat == exp_wp + exp_tail, "R6 write latency", lat, exp_wp + exp_tail);
      chk(we_low == exp_wp, "R5 we low cycles", we_low, exp_wp);
      chk(tail == exp_tail, "R6 closing cycles", tail, exp_tail);
      chk(rd_data == last_rd, "R4 rd_data held over write", rd_data, last_rd);
      exp_mem[int'(a)] = d;
    end else begin
      expv = exp_mem.exists(int'(a)) ? int'(exp_mem[int'(a)]) : 0;
      chk(lat == exp_rd_lat, "R3 read latency", lat, exp_rd_lat);
      chk(int'(rd_data) == expv, "R3 read data", rd_data, expv);
      last_rd = rd_data;
    end
    @(negedge clk);
    chk(!req_ready, "R3 ready single pulse", req_ready, 0);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n, "R1 deselected after access",
        {mem_sel_n, mem_sel, mem_we_n, mem_oe_n}, 4'b1011);
    chk(rd_data == last_rd, "R4 rd_data held after access", rd_data, last_rd);
  endtask

  initial begin : watchdog
    #500000;
    chk(1'b0, "watchdog global", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [16:0] a;
    exp_wp     = bigger(bigger(cyc(45), cyc(45)), cyc(25));
    exp_tail   = bigger(1, cyc(55) - exp_wp);
    exp_rd_lat = bigger(bigger(cyc(55), cyc(20)), cyc(55));
    exp_turn   = cyc(20);
    void'($urandom(32'd61357));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !req_ready,
        "R1 reset pin state", {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, req_ready}, 5'b10110);
    chk(rd_data == 8'h00, "R4 reset rd_data", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_sel_n && !mem_sel, "R1 idle deselect", {mem_sel_n, mem_sel}, 2'b10);

    // directed corners
    do_op(1'b0, 17'h00123, 8'h00);   // never written -> 0
    do_op(1'b1, 17'h00000, 8'h5A);
    do_op(1'b1, 17'h1FFFF, 8'hC3);   // back-to-back writes
    do_op(1'b0, 17'h1FFFF, 8'h00);
    do_op(1'b0, 17'h00000, 8'h00);   // read after read
    do_op(1'b1, 17'h00000, 8'hA7);   // write right after read: turnaround
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b1, 17'h0FF00, 8'hFF);
    do_op(1'b1, 17'h0FF00, 8'h01);   // overwrite same address
    do_op(1'b0, 17'h0FF00, 8'h00);

    for (int i = 0; i < 80; i++) begin
      a = ($urandom % 2 == 0) ? (17'h00000 | 17'($urandom % 32))
                              : (17'h1FFE0 | 17'($urandom % 32));
      do_op(1'($urandom % 2), a, 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule